// File: doc/BRIEF.md
# GPIO Port Edge Interrupt Unit

This block is the interrupt logic for a single 8-pin GPIO port. It takes the already-synchronised level of each pin. It compares each level with the one sampled a cycle earlier and, for every pin, looks for one chosen edge direction. When that edge occurs on an enabled pin, the block records it as a pending event. A test register can also force events directly, whatever the pins are doing.

All pending events that are enabled are combined into one registered interrupt line for the port. Software-side access uses a plain write strobe, a 2-bit register select and a data bus. A combinational read bus shows the register that the select currently points at. Pin output drive and pin modes live elsewhere.

Top module: `gpio_port_irq`

## Requirements
- R1: Register select 0 is the edge polarity register, with one bit per pin: 1 arms that pin for a low-to-high change and 0 arms it for a high-to-low change. It is written by a strobed write and reads back what was written.
- R2: Register select 1 is the enable register. An edge on pin i becomes an event only while bit i of this register is 1.
- R3: Register select 2 is the event register. Bit i is set at the clock edge where the sampled level of pin i differs from the level sampled one cycle before, in the direction armed for that pin.
- R4: Writing to the event register clears each bit written as 1 and leaves each bit written as 0 untouched.
- R5: Register select 3 is the force register. While bit i holds 1, event bit i is set every cycle, regardless of the pin level and of the enable bit. Writing 0 stops the forcing, and events that are already set remain until they are cleared.
- R6: When a new event for bit i and a clear of bit i fall in the same cycle, the bit ends up set.
- R7: `irq` is a registered signal. It is 1 in the cycle after any event bit is 1 together with its enable bit, and 0 in the cycle after no such pair exists.
- R8: Writing a new edge polarity does not by itself create an event. The new polarity applies to level comparisons from the next cycle onward.
- R9: Synchronous reset clears all four registers and `irq`. It also loads the level history from the pins, so a pin that is already high at reset does not produce an event afterwards.
- R10: `reg_rdata` shows the selected register combinationally, and reading has no side effect: in particular, reading the event register does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 8 | Synchronised pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 polarity, 1 enable, 2 event, 3 force) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Registered combined port interrupt |

## Verification
Random pin toggling is run against random polarity and enable settings, which separates rising from falling detection and gated from ungated pins. Interleaved writes of ones to the event register, some of them landing in the same cycle as a fresh edge, separate a correct write-one-to-clear from a plain overwrite and show that setting wins over clearing. Occasional force patterns show events being raised without any pin activity and with the enable off, while `irq` stays low for pins that are not enabled. Directed cases cover reset with pins already high and a polarity change while a pin is held steady, where any event would be spurious.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_POLARITY = 2'd0,
        SEL_ENABLE   = 2'd1,
        SEL_EVENT    = 2'd2,
        SEL_FORCE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } reg_cmd_t;

    // One pin: 1 when the level moved in the armed direction.
    function automatic logic pin_hit(input logic rise_armed,
                                     input logic now_lvl,
                                     input logic old_lvl);
        logic went_up;
        logic went_down;
        went_up   = now_lvl & ~old_lvl;
        went_down = ~now_lvl & old_lvl;
        return rise_armed ? went_up : went_down;
    endfunction

    // Sticky flag update: set dominates clear.
    function automatic logic flag_next(input logic cur,
                                       input logic set_req,
                                       input logic clr_req);
        return set_req | (cur & ~clr_req);
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  reg_cmd_t        cmd,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] evt_q,
    output logic [PINS-1:0] pol_q,
    output logic [PINS-1:0] ena_q,
    output logic [PINS-1:0] frc_q,
    output logic [PINS-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= '0;
            ena_q <= '0;
            frc_q <= '0;
        end else if (cmd.wr) begin
            unique case (cmd.sel)
                SEL_POLARITY: pol_q <= wdata;
                SEL_ENABLE:   ena_q <= wdata;
                SEL_FORCE:    frc_q <= wdata;
                default:      ;
            endcase
        end
    end

    always_comb begin
        unique case (cmd.sel)
            SEL_POLARITY: rdata = pol_q;
            SEL_ENABLE:   rdata = ena_q;
            SEL_EVENT:    rdata = evt_q;
            SEL_FORCE:    rdata = frc_q;
            default:      rdata = '0;
        endcase
    end

    // R1 / R2: a write lands in the addressed register on the next cycle
    a_r1_polarity_write: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_POLARITY) |=> (pol_q == $past(wdata)));
    a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_ENABLE) |=> (ena_q == $past(wdata)));

endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] lvl,
    input  logic [PINS-1:0] pol_q,
    output logic [PINS-1:0] hit
);

    logic [PINS-1:0] prev_q;

    // Level history is loaded from the pins during reset (R9).
    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign hit[i] = pin_hit(pol_q[i], lvl[i], prev_q[i]);
    end

    // R3: an edge hit always coincides with a level change
    a_r3_hit_needs_change: assert property (@(posedge clk) disable iff (rst)
        ((hit & ~(lvl ^ prev_q)) == '0));

    // R8: steady pins never hit, whatever the polarity register does
    a_r8_steady_no_hit: assert property (@(posedge clk) disable iff (rst)
        (lvl == $past(lvl)) |-> (hit == '0));

endmodule

// File: rtl/gpio_irq_event.sv
module gpio_irq_event
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] hit,
    input  logic [PINS-1:0] ena_q,
    input  logic [PINS-1:0] frc_q,
    input  logic [PINS-1:0] clr,
    output logic [PINS-1:0] evt_q,
    output logic            irq
);

    logic [PINS-1:0] set_req;
    logic [PINS-1:0] evt_d;

    assign set_req = (hit & ena_q) | frc_q;

    for (genvar i = 0; i < PINS; i++) begin : g_flag
        assign evt_d[i] = flag_next(evt_q[i], set_req[i], clr[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            irq   <= 1'b0;
        end else begin
            evt_q <= evt_d;
            irq   <= |(evt_q & ena_q);
        end
    end

    // R4: a cleared bit with no new set request drops
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((evt_q & $past(clr & ~set_req)) == '0));

    // R6: set wins over a clear in the same cycle
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        ((set_req & clr) != '0) |=> ((evt_q & $past(set_req & clr)) == $past(set_req & clr)));

    // R5: forced bits are set the cycle after
    a_r5_force_sets: assert property (@(posedge clk) disable iff (rst)
        (frc_q != '0) |=> ((evt_q & $past(frc_q)) == $past(frc_q)));

    // R2: a bit neither enabled nor forced cannot rise
    a_r2_gate: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(ena_q | frc_q)) == '0));

    // R7: no enabled pending event means irq low next cycle
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        ((evt_q & ena_q) == '0) |=> !irq);

endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_lvl,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [PINS-1:0] reg_wdata,
    output logic [PINS-1:0] reg_rdata,
    output logic            irq
);

    reg_cmd_t        cmd;
    logic [PINS-1:0] pol_q;
    logic [PINS-1:0] ena_q;
    logic [PINS-1:0] frc_q;
    logic [PINS-1:0] evt_q;
    logic [PINS-1:0] hit;
    logic [PINS-1:0] clr;

    assign cmd.wr  = reg_we;
    assign cmd.sel = reg_sel_e'(reg_addr);
    assign clr     = (cmd.wr && cmd.sel == SEL_EVENT) ? reg_wdata : '0;

    gpio_irq_cfg #(.PINS(PINS)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .wdata (reg_wdata),
        .evt_q (evt_q),
        .pol_q (pol_q),
        .ena_q (ena_q),
        .frc_q (frc_q),
        .rdata (reg_rdata)
    );

    gpio_irq_edge #(.PINS(PINS)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl   (pin_lvl),
        .pol_q (pol_q),
        .hit   (hit)
    );

    gpio_irq_event #(.PINS(PINS)) u_event (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .ena_q (ena_q),
        .frc_q (frc_q),
        .clr   (clr),
        .evt_q (evt_q),
        .irq   (irq)
    );

    // R10: with no event-register write, no new set and no force, events hold
    a_r10_read_no_side_effect: assert property (@(posedge clk) disable iff (rst)
        (!(reg_we && reg_addr == 2'd2) && hit == '0 && frc_q == '0) |=> (evt_q == $past(evt_q)));

endmodule

// File: tb/tb_gpio_port_irq.sv
module tb_gpio_port_irq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_lvl = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    logic [7:0] m_pol, m_ena, m_evt, m_frc, m_prev;
    logic       m_irq;

    always #5 clk = ~clk;

    gpio_port_irq dut (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_pol;
            2'd1: return m_ena;
            2'd2: return m_evt;
            default: return m_frc;
        endcase
    endfunction

    function automatic logic [7:0] model_hit(input logic [7:0] pol, input logic [7:0] now_l,
                                             input logic [7:0] old_l);
        return (pol & now_l & ~old_l) | (~pol & ~now_l & old_l);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check current outputs, let the edge pass, update model.
    task automatic cyc(input logic [7:0] lvl, input logic we, input logic [1:0] a,
                       input logic [7:0] wd, input string tag);
        logic [7:0] hitv, setv, clrv;
        logic       nirq;
        @(negedge clk);
        pin_lvl = lvl; reg_we = we; reg_addr = a; reg_wdata = wd;
        #1;
        check("R7 irq", {7'd0, irq}, {7'd0, m_irq});
        if (!we) check(tag, reg_rdata, model_read(a));
        @(posedge clk);
        hitv = model_hit(m_pol, lvl, m_prev);
        setv = (hitv & m_ena) | m_frc;
        clrv = (we && a == 2'd2) ? wd : 8'h00;
        nirq = |(m_evt & m_ena);
        m_evt = setv | (m_evt & ~clrv);
        m_irq = nirq;
        m_prev = lvl;
        if (we) begin
            if (a == 2'd0) m_pol = wd;
            if (a == 2'd1) m_ena = wd;
            if (a == 2'd3) m_frc = wd;
        end
    endtask

    function automatic string tag_for(input logic [1:0] a);
        case (a)
            2'd0: return "R1 polarity";
            2'd1: return "R2 enable";
            2'd2: return "R3 event";
            default: return "R5 force";
        endcase
    endfunction

    initial begin
        logic [7:0] lvl;
        void'($urandom(32'd20240611));
        // R9: reset with every pin high
        pin_lvl = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        m_pol = 0; m_ena = 0; m_evt = 0; m_frc = 0; m_prev = 8'hFF; m_irq = 0;
        for (int a = 0; a < 4; a++) cyc(8'hFF, 1'b0, a[1:0], 8'h00, "R9 reset state");
        // arm all for falling, enable all, hold pins high: no event (R9)
        cyc(8'hFF, 1'b1, 2'd1, 8'hFF, "R2 enable");
        cyc(8'hFF, 1'b0, 2'd2, 8'h00, "R9 no event after reset");
        // R8: switch to rising while high, then read: no event
        cyc(8'hFF, 1'b1, 2'd0, 8'hFF, "R8 polarity");
        cyc(8'hFF, 1'b0, 2'd2, 8'h00, "R8 no spurious event");
        cyc(8'hFF, 1'b0, 2'd2, 8'h00, "R8 no spurious event");
        // falls now ignored (rising armed), then rise on pin 0 sets bit 0
        cyc(8'h00, 1'b0, 2'd2, 8'h00, "R8 new polarity used");
        cyc(8'h01, 1'b0, 2'd2, 8'h00, "R3 event");
        cyc(8'h01, 1'b0, 2'd2, 8'h00, "R10 read keeps event");
        cyc(8'h01, 1'b0, 2'd2, 8'h00, "R10 read keeps event");
        // R4: clear with 0 bits does nothing, clear bit 0
        cyc(8'h01, 1'b1, 2'd2, 8'h00, "R4 clear");
        cyc(8'h01, 1'b0, 2'd2, 8'h00, "R4 zero write keeps");
        cyc(8'h00, 1'b1, 2'd2, 8'h01, "R4 clear");
        cyc(8'h00, 1'b0, 2'd2, 8'h00, "R4 cleared");
        // R6: rise on pin 1 in the same cycle as a clear of bit 1
        cyc(8'h02, 1'b1, 2'd2, 8'h02, "R6 set wins");
        cyc(8'h02, 1'b0, 2'd2, 8'h00, "R6 set wins");
        // R5: disable all, force bits 4 and 5
        cyc(8'h02, 1'b1, 2'd1, 8'h00, "R2 enable");
        cyc(8'h02, 1'b1, 2'd2, 8'hFF, "R4 clear");
        cyc(8'h02, 1'b1, 2'd3, 8'h30, "R5 force");
        cyc(8'h02, 1'b1, 2'd2, 8'h30, "R5 force beats clear");
        cyc(8'h02, 1'b0, 2'd2, 8'h00, "R5 forced event");
        cyc(8'h02, 1'b1, 2'd3, 8'h00, "R5 force off");
        cyc(8'h02, 1'b0, 2'd2, 8'h00, "R5 event stays");
        cyc(8'h02, 1'b1, 2'd1, 8'h10, "R7 enable one");
        cyc(8'h02, 1'b0, 2'd2, 8'h00, "R7 irq rises");
        cyc(8'h02, 1'b0, 2'd2, 8'h00, "R7 irq high");
        cyc(8'h02, 1'b1, 2'd2, 8'h10, "R7 clear");
        cyc(8'h02, 1'b0, 2'd2, 8'h00, "R7 irq falls");
        cyc(8'h02, 1'b0, 2'd2, 8'h00, "R7 irq low");
        // random phase
        lvl = 8'h02;
        for (int k = 0; k < 3000; k++) begin
            logic       we;
            logic [1:0] a;
            logic [7:0] wd;
            lvl = lvl ^ 8'($urandom);
            we  = ($urandom % 4) == 0;
            a   = 2'($urandom);
            wd  = 8'($urandom);
            if (we && a == 2'd3 && ($urandom % 4) != 0) wd = 8'h00;
            cyc(lvl, we, a, wd, tag_for(a));
        end
        cyc(lvl, 1'b0, 2'd2, 8'h00, "R3 event");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule